// File: doc/BRIEF.md
# Event-Selectable Performance Counter Unit

This unit counts hardware events for software. Two vectors of one-cycle event pulses come in, one for the read channel and one for the write channel. Each vector has one line per event code, and every line carries a source-port tag. The unit keeps a separate counter for every channel and code pair. Software then chooses which of these counters it reads back. A free-running cycle counter sits next to the event counters and gives a time base.

Software uses a small 32-bit register bus with word addresses. The 64-bit control and counter registers are reached as a low half and a high half. The control word does four things. It picks the channel and event code to report. It can freeze or clear all event counters. It can limit counting to pulses from one source port. The counter register returns the selected count, and its top four bits echo the code being reported. After changing the selection, software polls until the echo matches.

Reading a low half stores the matching high half in a shadow register. A later read of the high half returns that stored value, so a carry between the two bus reads cannot tear the 64-bit result.

Top module: `perf_event_unit`

## Requirements
- R1: After reset the control word, the counter register and the cycle counter all read 0. The reported selection is code 0 on the read channel.
- R2: A read strobe sampled at a clock edge returns its data on `bus_rdata_o`, with `bus_rvalid_o` high for one cycle, right after that edge. Word address 0 is control low, 1 is control high (always 0), 2 is counter low, 3 is counter high, 4 is cycle low and 5 is cycle high. Any other address reads 0.
- R3: Each channel/code pair has its own counter. The counter adds one for each pulse on its own input line. Changing the selection loses no counts.
- R4: In the counter register, bits 59:0 hold the selected count and bits 63:60 hold the code being reported. These top bits are bits 31:28 of the high-half read.
- R5: After a control write in cycle n, the reported code and count follow the new selection from cycle n+2. Until then the previous selection is still reported.
- R6: Control bit 8 freezes all event counters, which hold their values while it is set. The cycle counter keeps running.
- R7: Writing 1 to control bit 0 clears every event counter at the edge after the write. Bit 0 always reads back 0, and the cycle counter is not affected.
- R8: Control bits 19:16 select the code. A write whose code is above NUM_EVT-1 (7 by default) leaves the code field unchanged, but the other fields in that write still take effect.
- R9: Control bit 20 selects the channel: 0 for read, 1 for write.
- R10: Control bit 23 turns on port filtering, and bits 26:25 give the port. With filtering on, only pulses tagged with that port are counted. With it off, pulses from every port are counted.
- R11: The 64-bit cycle counter adds one on every clock edge outside reset. Only reset clears it.
- R12: A read of counter low or cycle low stores the upper half of that register in a shadow. The next read of the matching high half returns the shadow, even if the register has changed since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_rvalid_o | output | 1 | Read data valid |
| ev_rd_i | input | NUM_EVT | Read-channel event pulses, one per code |
| ev_rd_tag_i | input | NUM_EVT*PORT_W | Port tag of each read-channel pulse |
| ev_wr_i | input | NUM_EVT | Write-channel event pulses, one per code |
| ev_wr_tag_i | input | NUM_EVT*PORT_W | Port tag of each write-channel pulse |

## Verification
Some rules can be checked on every cycle, and the assertions cover these. The echoed code trails the written code by exactly two cycles. Frozen counters never move. A clear leaves every counter at zero. The cycle counter steps by one. The stored code never exceeds the maximum. Bit 0 of the control word never reads back 1. Other behaviour needs a scenario, and the bench's scenarios show it. These include counts kept across selection changes, the read/write channel split, port filtering against mixed tags, rejection of out-of-range codes, and the shadow returning an old upper half after the selection has moved on.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int BUS_W    = 32;
  localparam int REG_W    = 64;
  localparam int CODE_W   = 4;
  localparam int CLR_BIT  = 0;
  localparam int FRZ_BIT  = 8;
  localparam int CODE_LSB = 16;
  localparam int CHAN_BIT = 20;
  localparam int FILT_BIT = 23;
  localparam int PORT_LSB = 25;
  localparam int ECHO_LSB = 60;

  localparam logic [2:0] ADR_CTRL_LO = 3'd0;
  localparam logic [2:0] ADR_CTRL_HI = 3'd1;
  localparam logic [2:0] ADR_CNT_LO  = 3'd2;
  localparam logic [2:0] ADR_CNT_HI  = 3'd3;
  localparam logic [2:0] ADR_CYC_LO  = 3'd4;
  localparam logic [2:0] ADR_CYC_HI  = 3'd5;

  typedef enum logic {CH_RD = 1'b0, CH_WR = 1'b1} chan_e;

  typedef struct packed {
    chan_e             chan;
    logic [CODE_W-1:0] code;
  } sel_t;
endpackage

// File: rtl/pcu_event_cnt.sv
module pcu_event_cnt #(
  parameter int CNT_W  = 60,
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              frz,
  input  logic              pulse,
  input  logic [PORT_W-1:0] tag,
  input  logic              filt_en,
  input  logic [PORT_W-1:0] filt_port,
  output logic [CNT_W-1:0]  cnt_o
);
  logic hit;

  assign hit = pulse && (!filt_en || (tag == filt_port));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_o <= '0;
    end else if (!frz && hit) begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int PORT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic              frz_o,
  output logic              clr_o,
  output logic              filt_en_o,
  output logic [PORT_W-1:0] filt_port_o,
  output sel_t              sel_o,
  output sel_t              rep_o,
  output logic [BUS_W-1:0]  ctrl_word_o
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NUM_EVT - 1);

  sel_t              sel_mid;
  logic              hit;
  logic              code_ok;
  logic [CODE_W-1:0] new_code;
  logic              unused_wdata;

  assign hit          = wr_en && (addr == ADR_CTRL_LO);
  assign new_code     = wdata[CODE_LSB +: CODE_W];
  assign code_ok      = (new_code <= MAX_CODE);
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      frz_o       <= 1'b0;
      clr_o       <= 1'b0;
      filt_en_o   <= 1'b0;
      filt_port_o <= '0;
      sel_o       <= '0;
      sel_mid     <= '0;
      rep_o       <= '0;
    end else begin
      clr_o   <= 1'b0;
      sel_mid <= sel_o;
      rep_o   <= sel_mid;
      if (hit) begin
        frz_o       <= wdata[FRZ_BIT];
        clr_o       <= wdata[CLR_BIT];
        filt_en_o   <= wdata[FILT_BIT];
        filt_port_o <= wdata[PORT_LSB +: PORT_W];
        sel_o.chan  <= chan_e'(wdata[CHAN_BIT]);
        if (code_ok) begin
          sel_o.code <= new_code;
        end
      end
    end
  end

  always_comb begin
    ctrl_word_o                        = '0;
    ctrl_word_o[FRZ_BIT]               = frz_o;
    ctrl_word_o[CODE_LSB +: CODE_W]    = sel_o.code;
    ctrl_word_o[CHAN_BIT]              = sel_o.chan;
    ctrl_word_o[FILT_BIT]              = filt_en_o;
    ctrl_word_o[PORT_LSB +: PORT_W]    = filt_port_o;
  end
endmodule

// File: rtl/pcu_readout.sv
module pcu_readout
  import pcu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] ctrl_word,
  input  logic [REG_W-1:0] cnt_word,
  input  logic [REG_W-1:0] cyc_word,
  output logic [BUS_W-1:0] rdata_o,
  output logic             rvalid_o
);
  logic [BUS_W-1:0] cnt_shadow;
  logic [BUS_W-1:0] cyc_shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o    <= '0;
      rvalid_o   <= 1'b0;
      cnt_shadow <= '0;
      cyc_shadow <= '0;
    end else begin
      rvalid_o <= rd_en;
      if (rd_en) begin
        case (addr)
          ADR_CTRL_LO: rdata_o <= ctrl_word;
          ADR_CTRL_HI: rdata_o <= '0;
          ADR_CNT_LO: begin
            rdata_o    <= cnt_word[BUS_W-1:0];
            cnt_shadow <= cnt_word[REG_W-1:BUS_W];
          end
          ADR_CNT_HI:  rdata_o <= cnt_shadow;
          ADR_CYC_LO: begin
            rdata_o    <= cyc_word[BUS_W-1:0];
            cyc_shadow <= cyc_word[REG_W-1:BUS_W];
          end
          ADR_CYC_HI:  rdata_o <= cyc_shadow;
          default:     rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/perf_event_unit.sv
module perf_event_unit
  import pcu_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int PORT_W  = 2,
  parameter int CNT_W   = 60
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr_i,
  input  logic                      bus_rd_i,
  input  logic [2:0]                bus_addr_i,
  input  logic [31:0]               bus_wdata_i,
  output logic [31:0]               bus_rdata_o,
  output logic                      bus_rvalid_o,
  input  logic [NUM_EVT-1:0]        ev_rd_i,
  input  logic [NUM_EVT*PORT_W-1:0] ev_rd_tag_i,
  input  logic [NUM_EVT-1:0]        ev_wr_i,
  input  logic [NUM_EVT*PORT_W-1:0] ev_wr_tag_i
);
  localparam int NUM_CNT = 2 * NUM_EVT;
  localparam int IDX_W   = $clog2(NUM_CNT);

  logic                             frz_q;
  logic                             clr_q;
  logic                             filt_en;
  logic [PORT_W-1:0]                filt_port;
  sel_t                             sel_q;
  sel_t                             rep_q;
  logic [CODE_W-1:0]                ctrl_code;
  logic [CODE_W-1:0]                rep_code;
  logic [BUS_W-1:0]                 ctrl_word;
  logic [NUM_CNT-1:0][CNT_W-1:0]    cnt_all;
  logic [IDX_W-1:0]                 rep_idx;
  logic [CNT_W-1:0]                 cnt_sel;
  logic [REG_W-1:0]                 cnt_word;
  logic [REG_W-1:0]                 cyc_q;

  pcu_ctrl #(.NUM_EVT(NUM_EVT), .PORT_W(PORT_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(bus_wr_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .frz_o(frz_q), .clr_o(clr_q),
    .filt_en_o(filt_en), .filt_port_o(filt_port),
    .sel_o(sel_q), .rep_o(rep_q), .ctrl_word_o(ctrl_word)
  );

  assign ctrl_code = sel_q.code;
  assign rep_code  = rep_q.code;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      logic              pulse;
      logic [PORT_W-1:0] tag;
      if (ch == 0) begin : g_rd
        assign pulse = ev_rd_i[e];
        assign tag   = ev_rd_tag_i[e*PORT_W +: PORT_W];
      end else begin : g_wr
        assign pulse = ev_wr_i[e];
        assign tag   = ev_wr_tag_i[e*PORT_W +: PORT_W];
      end
      pcu_event_cnt #(.CNT_W(CNT_W), .PORT_W(PORT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr_q), .frz(frz_q),
        .pulse(pulse), .tag(tag), .filt_en(filt_en),
        .filt_port(filt_port), .cnt_o(cnt_all[ch*NUM_EVT+e])
      );
    end
  end

  assign rep_idx = IDX_W'(int'(rep_q.chan) * NUM_EVT + int'(rep_q.code));
  assign cnt_sel = cnt_all[rep_idx];

  always_comb begin
    cnt_word                           = '0;
    cnt_word[CNT_W-1:0]                = cnt_sel;
    cnt_word[ECHO_LSB +: CODE_W]       = rep_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
    end else begin
      cyc_q <= cyc_q + 64'd1;
    end
  end

  pcu_readout u_readout (
    .clk(clk), .rst(rst), .rd_en(bus_rd_i), .addr(bus_addr_i),
    .ctrl_word(ctrl_word), .cnt_word(cnt_word), .cyc_word(cyc_q),
    .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
  );
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int NUM_EVT = 8,
  parameter int CNT_W   = 60
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         bus_rd_i,
  input logic [2:0]                   bus_addr_i,
  input logic [31:0]                  bus_rdata_o,
  input logic                         bus_rvalid_o,
  input logic                         frz_q,
  input logic                         clr_q,
  input logic [2*NUM_EVT*CNT_W-1:0]   cnt_flat,
  input logic [3:0]                   ctrl_code,
  input logic [3:0]                   rep_code,
  input logic [63:0]                  cyc_q
);
  localparam logic [3:0] MAX_CODE = 4'(NUM_EVT - 1);

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    bus_rd_i |=> bus_rvalid_o);  // R2

  AST_ECHO_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> rep_code == $past(ctrl_code, 2));  // R5

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ($past(frz_q) && !$past(clr_q) && !$past(rst)) |-> cnt_flat == $past(cnt_flat));  // R6

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    $past(clr_q) |-> cnt_flat == '0);  // R7

  AST_CLR_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid_o && $past(bus_addr_i) == 3'd0) |-> !bus_rdata_o[0]);  // R7

  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ctrl_code <= MAX_CODE);  // R8

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cyc_q == $past(cyc_q) + 64'd1);  // R11
endmodule

bind perf_event_unit pcu_checker #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) i_pcu_checker (
  .clk(clk), .rst(rst), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
  .bus_rdata_o(bus_rdata_o), .bus_rvalid_o(bus_rvalid_o),
  .frz_q(frz_q), .clr_q(clr_q), .cnt_flat(cnt_all),
  .ctrl_code(ctrl_code), .rep_code(rep_code), .cyc_q(cyc_q)
);

// File: tb/test_perf_event_unit.sv
module test_perf_event_unit;
  localparam int NUM_EVT = 8;
  localparam int PORT_W  = 2;
  localparam int CNT_W   = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic                      bus_wr_i = 1'b0;
  logic                      bus_rd_i = 1'b0;
  logic [2:0]                bus_addr_i = '0;
  logic [31:0]               bus_wdata_i = '0;
  logic [31:0]               bus_rdata_o;
  logic                      bus_rvalid_o;
  logic [NUM_EVT-1:0]        ev_rd_i = '0;
  logic [NUM_EVT*PORT_W-1:0] ev_rd_tag_i = '0;
  logic [NUM_EVT-1:0]        ev_wr_i = '0;
  logic [NUM_EVT*PORT_W-1:0] ev_wr_tag_i = '0;

  perf_event_unit #(.NUM_EVT(NUM_EVT), .PORT_W(PORT_W), .CNT_W(CNT_W)) i_perf_event_unit (
    .clk(clk), .rst(rst), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .bus_rvalid_o(bus_rvalid_o),
    .ev_rd_i(ev_rd_i), .ev_rd_tag_i(ev_rd_tag_i),
    .ev_wr_i(ev_wr_i), .ev_wr_tag_i(ev_wr_tag_i)
  );

  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;
  logic [63:0] tb_cyc;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // Reference cycle count from R11: one per edge outside reset.
  always @(posedge clk) begin
    if (rst) tb_cyc <= '0;
    else     tb_cyc <= tb_cyc + 64'd1;
  end

  // Monitor: compare each read response against the scoreboard.
  always @(negedge clk) begin
    logic [31:0] e;
    string       t;
    if (bus_rvalid_o && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (bus_rdata_o !== e) begin
        n_fail++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", t, bus_rdata_o, e);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    bus_rd_i   = 1'b1;
    bus_addr_i = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd_i = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    bus_wr_i    = 1'b1;
    bus_addr_i  = 3'd0;
    bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit ch, input int code, input int tag);
    if (!ch) begin
      ev_rd_i[code] = 1'b1;
      ev_rd_tag_i[code*PORT_W +: PORT_W] = PORT_W'(tag);
    end else begin
      ev_wr_i[code] = 1'b1;
      ev_wr_tag_i[code*PORT_W +: PORT_W] = PORT_W'(tag);
    end
    @(negedge clk);
    ev_rd_i = '0;
    ev_wr_i = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, 32'h0, "R1 control after reset");
    rd(3'd2, 32'h0, "R1 counter low after reset");
    rd(3'd3, 32'h0, "R1 counter high after reset");
    // R2 control high half and unmapped address
    rd(3'd1, 32'h0, "R2 control high half");
    rd(3'd7, 32'h0, "R2 unmapped address");
    // R11 cycle counter
    rd(3'd4, tb_cyc[31:0], "R11 cycle low");
    rd(3'd5, 32'h0, "R11 cycle high");

    // R3/R4: count read-channel code 3, other code interleaved, mixed tags
    wr(32'h0003_0000);
    idle(3);
    pulse(0, 3, 0); pulse(0, 2, 1); pulse(0, 3, 1); pulse(0, 3, 2);
    pulse(0, 2, 3); pulse(0, 3, 3); pulse(0, 3, 0);
    rd(3'd2, 32'd5, "R3 code 3 count");
    rd(3'd3, 32'h3000_0000, "R4 echo code 3");

    // R5: echo holds old selection for two cycles after write
    wr(32'h0002_0000);
    rd(3'd2, 32'd5, "R5 old count right after write");
    rd(3'd3, 32'h3000_0000, "R5 old code right after write");
    rd(3'd2, 32'd2, "R5 new count of code 2");
    rd(3'd3, 32'h2000_0000, "R5 new echo code 2");

    // R9: write channel, code 1
    wr(32'h0011_0000);
    idle(3);
    pulse(1, 1, 0); pulse(0, 1, 0); pulse(1, 1, 1); pulse(0, 1, 2); pulse(1, 1, 3);
    rd(3'd2, 32'd3, "R9 write channel count");
    rd(3'd3, 32'h1000_0000, "R9 echo code 1");

    // R6: freeze
    wr(32'h0011_0100);
    idle(2);
    pulse(1, 1, 0); pulse(1, 1, 0); pulse(1, 1, 1); pulse(1, 1, 2);
    rd(3'd2, 32'd3, "R6 frozen count holds");
    rd(3'd0, 32'h0011_0100, "R6 control readback frozen");
    wr(32'h0011_0000);
    idle(2);
    pulse(1, 1, 0); pulse(1, 1, 3);
    rd(3'd2, 32'd5, "R6 counting after unfreeze");

    // R3: earlier counter survives selection changes
    wr(32'h0003_0000);
    idle(3);
    rd(3'd2, 32'd5, "R3 code 3 count kept");

    // R7: clear
    wr(32'h0003_0001);
    idle(2);
    rd(3'd2, 32'd0, "R7 cleared count");
    rd(3'd0, 32'h0003_0000, "R7 clear bit reads 0");
    wr(32'h0011_0000);
    idle(3);
    rd(3'd2, 32'd0, "R7 write channel also cleared");
    wr(32'h0000_0101);
    idle(1);
    rd(3'd4, tb_cyc[31:0], "R7 cycle counter unaffected by clear and freeze");
    wr(32'h0000_0000);

    // R10: port filter on port 2, code 4 read channel
    wr(32'h0484_0000);
    idle(3);
    pulse(0, 4, 2); pulse(0, 4, 1); pulse(0, 4, 2); pulse(0, 4, 3); pulse(0, 4, 2);
    rd(3'd2, 32'd3, "R10 filtered count");
    wr(32'h0004_0000);
    idle(2);
    pulse(0, 4, 1); pulse(0, 4, 3);
    rd(3'd2, 32'd5, "R10 unfiltered count");

    // R8: out-of-range code rejected, maximum accepted
    wr(32'h0009_0000);
    rd(3'd0, 32'h0004_0000, "R8 code 9 rejected");
    idle(3);
    rd(3'd2, 32'd5, "R8 count after rejected code");
    rd(3'd3, 32'h4000_0000, "R8 echo stays code 4");
    wr(32'h0007_0000);
    rd(3'd0, 32'h0007_0000, "R8 maximum code accepted");
    idle(3);

    // R12: shadow keeps upper half from the low-half read
    rd(3'd2, 32'd0, "R12 low read of code 7");
    wr(32'h0005_0000);
    idle(3);
    rd(3'd3, 32'h7000_0000, "R12 high returns shadowed code 7");
    rd(3'd4, tb_cyc[31:0], "R12 cycle low");
    rd(3'd5, 32'h0, "R12 cycle high shadow");

    wait (exp_q.size() == 0);
    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule